// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It takes the memory through its start-up procedure and then raises a ready flag. After reset it holds clock-enable and the data masks high and issues only no-operation commands. This quiet period is long enough to cover the required stable-clock time of at least 200 microseconds. The length is computed from a clock-frequency parameter in kHz and rounded up to whole cycles.

When the quiet period is over, the block precharges every bank. It then issues a configurable number of auto-refresh commands, two or more, and a load of the mode register with the mode word taken from its input. A parameter decides whether the mode register load comes before or after the refreshes. After each command the block inserts a parameterized number of no-operation cycles, so that the memory's command recovery times are met. Once the last of these gaps has passed, the ready flag rises and stays high until the next reset. Refresh scheduling and data access belong to the rest of the controller.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and at every cycle afterwards, `cke` and every bit of `dqm` are 1. During reset the command is NOP and `ready` is 0.
- R2: After reset falls, the command stays NOP for WAIT_CYC cycles. WAIT_CYC = ceil(CLK_KHZ * WAIT_US / 1000). The first non-NOP command appears on the cycle after the WAIT_CYC-th clock edge following release.
- R3: The first command is a precharge. During it, address bit AP_BIT (default 10) is 1, all other address bits are 0 and `ba` is 0, which selects all banks.
- R4: Exactly N_REF auto-refresh commands are issued (N_REF >= 2). Each has `ba` = 0.
- R5: Exactly one mode register set is issued. During it, `addr[MODE_W-1:0]` equals `mode_word`, and the address bits above MODE_W and `ba` are all 0.
- R6: With MRS_FIRST = 0, all refreshes come before the mode register set. With MRS_FIRST = 1, the mode register set directly follows the precharge and the refreshes follow it.
- R7: A precharge is followed by exactly T_RP NOP cycles, a refresh by T_RFC, and a mode register set by T_MRD. The next step begins on the cycle after that gap.
- R8: `ready` rises on the cycle after the gap of the last command. It stays at 1 until reset, and a reset clears it at the next edge. While `ready` is 1 the command is NOP.
- R9: The command is the 4-bit code {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge = 0010, auto-refresh = 0001, mode register set = 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | MODE_W | Value loaded into the memory mode register |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | DQM_W | Data mask lines, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe command line |
| cas_n | output | 1 | Column strobe command line |
| we_n | output | 1 | Write enable command line |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank select |
| ready | output | 1 | Initialization complete, sticky until reset |

## Verification
Two instances run side by side with different parameter sets. The first has an integral 125 MHz wait, refreshes before the mode load, and two refreshes. The second has a clock value that forces round-up, the mode load first, three refreshes, and other gap lengths. Comparing the two separates a wrong order choice, an off-by-one in the rounded wait, a wrong refresh count and gap lengths swapped between command types. Each instance gets a different mode word, so a mode field that is not wired through, or is shifted, shows up in the address. A final reset after ready shows that the flag is sticky only until reset.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_PWR,
        ST_PRE,
        ST_REF,
        ST_MRS,
        ST_GAP,
        ST_DONE
    } init_state_e;

    // Round a microsecond wait up to whole clock cycles.
    function automatic int unsigned wait_cycles(input int unsigned clk_khz,
                                                input int unsigned us);
        longint unsigned prod;
        prod = longint'(clk_khz) * longint'(us);
        return int'((prod + 64'd999) / 64'd1000);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned CW      = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CW'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int unsigned CW        = 16,
    parameter int unsigned N_REF     = 2,
    parameter bit          MRS_FIRST = 1'b0,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RFC     = 7,
    parameter int unsigned T_MRD     = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output init_state_e   state,
    output logic          ready
);
    localparam int unsigned RCW = $clog2(N_REF + 1);

    init_state_e    nxt;
    logic [RCW-1:0] ref_cnt;
    logic           mrs_done;
    logic           refs_left;
    init_state_e    pick;

    assign refs_left = (ref_cnt < RCW'(N_REF));

    always_comb begin
        if (!refs_left && mrs_done)
            pick = ST_DONE;
        else if (!mrs_done && (MRS_FIRST || !refs_left))
            pick = ST_MRS;
        else
            pick = ST_REF;
    end

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        unique case (state)
            ST_PWR:  if (expired) nxt = ST_PRE;
            ST_PRE:  begin load = 1'b1; load_val = CW'(T_RP - 1);  nxt = ST_GAP; end
            ST_REF:  begin load = 1'b1; load_val = CW'(T_RFC - 1); nxt = ST_GAP; end
            ST_MRS:  begin load = 1'b1; load_val = CW'(T_MRD - 1); nxt = ST_GAP; end
            ST_GAP:  if (expired) nxt = pick;
            ST_DONE: nxt = ST_DONE;
            default: nxt = ST_PWR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_PWR;
            ref_cnt  <= '0;
            mrs_done <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_REF) ref_cnt  <= ref_cnt + 1'b1;
            if (state == ST_MRS) mrs_done <= 1'b1;
        end
    end

    assign ready = (state == ST_DONE);
endmodule

// File: rtl/sdram_init_encode.sv
module sdram_init_encode
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BA_W   = 1,
    parameter int unsigned MODE_W = 10,
    parameter int unsigned AP_BIT = 10
) (
    input  init_state_e       state,
    input  logic [MODE_W-1:0] mode_word,
    output sdram_cmd_e        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        unique case (state)
            ST_PRE: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b1;
            end
            ST_REF: cmd = CMD_REF;
            ST_MRS: begin
                cmd              = CMD_MRS;
                addr[MODE_W-1:0] = mode_word;
            end
            default: cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 125000,
    parameter int unsigned WAIT_US   = 200,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RFC     = 7,
    parameter int unsigned T_MRD     = 2,
    parameter int unsigned N_REF     = 2,
    parameter bit          MRS_FIRST = 1'b0,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BA_W      = 1,
    parameter int unsigned MODE_W    = 10,
    parameter int unsigned AP_BIT    = 10,
    parameter int unsigned DQM_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_word,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              ready
);
    localparam int unsigned WAIT_CYC = wait_cycles(CLK_KHZ, WAIT_US);
    localparam int unsigned MAX_CNT  = max2(max2(WAIT_CYC, T_RP), max2(T_RFC, T_MRD));
    localparam int unsigned CW       = $clog2(MAX_CNT + 1);

    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_expired;
    init_state_e   state;
    sdram_cmd_e    cmd;

    sdram_init_timer #(.CW(CW), .RST_VAL(WAIT_CYC - 1)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_expired)
    );

    sdram_init_fsm #(
        .CW(CW), .N_REF(N_REF), .MRS_FIRST(MRS_FIRST),
        .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
    ) u_fsm (
        .clk(clk), .rst(rst), .expired(t_expired),
        .load(t_load), .load_val(t_val), .state(state), .ready(ready)
    );

    sdram_init_encode #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_W(MODE_W), .AP_BIT(AP_BIT)
    ) u_enc (
        .state(state), .mode_word(mode_word), .cmd(cmd), .addr(addr), .ba(ba)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign cke = 1'b1;
    assign dqm = '1;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 125000,
    parameter int unsigned WAIT_US   = 200,
    parameter int unsigned N_REF     = 2,
    parameter bit          MRS_FIRST = 1'b0,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BA_W      = 1,
    parameter int unsigned MODE_W    = 10,
    parameter int unsigned AP_BIT    = 10,
    parameter int unsigned DQM_W     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic [DQM_W-1:0]  dqm,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              ready
);
    localparam int unsigned WAIT_CYC = wait_cycles(CLK_KHZ, WAIT_US);

    logic [3:0] cmd;
    int unsigned since;
    int unsigned refs;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= 0;
            refs  <= 0;
        end else begin
            if (since < WAIT_CYC) since <= since + 1;
            if (cmd == 4'b0001) refs <= refs + 1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (cmd == 4'b0111 && !ready && cke && (&dqm)));

    // R2
    a_r2_quiet_window: assert property (@(posedge clk) disable iff (rst)
        (cmd != 4'b0111) |-> (since >= WAIT_CYC));

    // R3
    a_r3_precharge_all: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0010) |-> (addr == (ADDR_W'(1) << AP_BIT) && ba == '0));

    // R4
    a_r4_refresh_bank: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0001) |-> (ba == '0 && refs < N_REF));

    // R5
    a_r5_mode_reserved: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000) |-> (addr[ADDR_W-1:MODE_W] == '0 && ba == '0));

    // R6
    a_r6_order: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000) |-> (MRS_FIRST ? (refs == 0) : (refs == N_REF)));

    // R7
    a_r7_gap_follows: assert property (@(posedge clk) disable iff (rst)
        (cmd != 4'b0111) |=> (cmd == 4'b0111));

    // R8
    a_r8_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cmd == 4'b0111 && refs == N_REF));
endmodule

bind sdram_init_seq sdram_init_chk #(
    .CLK_KHZ(CLK_KHZ), .WAIT_US(WAIT_US), .N_REF(N_REF), .MRS_FIRST(MRS_FIRST),
    .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_W(MODE_W), .AP_BIT(AP_BIT), .DQM_W(DQM_W)
) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .dqm(dqm), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .ready(ready)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    typedef struct {
        int         cyc;
        logic [3:0] cmd;
        logic [11:0] addr;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [9:0]  mode_a = 10'h233;
    logic [9:0]  mode_b = 10'h022;
    logic        cke_a, cke_b, cs_a, cs_b, ras_a, ras_b, cas_a, cas_b, we_a, we_b;
    logic        rdy_a, rdy_b;
    logic [1:0]  dqm_a, dqm_b;
    logic [11:0] addr_a, addr_b;
    logic [0:0]  ba_a, ba_b;

    sdram_init_seq u_dut (
        .clk(clk), .rst(rst), .mode_word(mode_a), .cke(cke_a), .dqm(dqm_a),
        .cs_n(cs_a), .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a),
        .addr(addr_a), .ba(ba_a), .ready(rdy_a)
    );

    sdram_init_seq #(
        .CLK_KHZ(100003), .T_RP(2), .T_RFC(9), .T_MRD(3), .N_REF(3), .MRS_FIRST(1'b1)
    ) u_dut_b (
        .clk(clk), .rst(rst), .mode_word(mode_b), .cke(cke_b), .dqm(dqm_b),
        .cs_n(cs_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b),
        .addr(addr_b), .ba(ba_b), .ready(rdy_b)
    );

    exp_t q_a[$];
    exp_t q_b[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    int   rdy_cyc_a, rdy_cyc_b;
    bit   seen_a = 0, seen_b = 0;
    bit   pins_bad = 0;
    bit   running = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int which, input int c, input logic [3:0] k,
                        input logic [11:0] a);
        exp_t e;
        e.cyc = c; e.cmd = k; e.addr = a;
        if (which == 0) q_a.push_back(e); else q_b.push_back(e);
    endtask

    // Driver: build the expected command stream from R2..R7.
    task automatic plan(input int which, input bit mrs_first, input int nref,
                        input int w, input int trp, input int trfc, input int tmrd,
                        input logic [9:0] mode, output int rdy);
        int t;
        t = w;
        push(which, t, C_PRE, 12'h400);
        t = t + 1 + trp;
        if (mrs_first) begin
            push(which, t, C_MRS, {2'b00, mode}); t = t + 1 + tmrd;
        end
        for (int i = 0; i < nref; i++) begin
            push(which, t, C_REF, 12'h000); t = t + 1 + trfc;
        end
        if (!mrs_first) begin
            push(which, t, C_MRS, {2'b00, mode}); t = t + 1 + tmrd;
        end
        rdy = t;
    endtask

    task automatic mon(input int which, input logic [3:0] k, input logic [11:0] a,
                       input logic [0:0] b, input logic r, input int rexp,
                       inout bit seen);
        exp_t e;
        string tag;
        tag = (which == 0) ? "A" : "B";
        if (k != C_NOP) begin
            if ((which == 0 ? q_a.size() : q_b.size()) == 0) begin
                check(0, "R8", {tag, " extra command"}, int'(k), int'(C_NOP));
            end else begin
                e = (which == 0) ? q_a.pop_front() : q_b.pop_front();
                check(cyc == e.cyc, "R7", {tag, " command cycle (R2 timing)"}, cyc, e.cyc);
                check(k == e.cmd, "R6", {tag, " command code R9"}, int'(k), int'(e.cmd));
                check(a == e.addr, "R5", {tag, " address R3"}, int'(a), int'(e.addr));
                check(b == 1'b0, "R4", {tag, " bank"}, int'(b), 0);
            end
        end
        if (r && !seen) begin
            seen = 1;
            check(cyc == rexp, "R8", {tag, " ready rise cycle"}, cyc, rexp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Monitor
    always @(negedge clk) begin
        if (running && !rst) begin
            if (!(cke_a && cke_b && (&dqm_a) && (&dqm_b))) pins_bad = 1;
            mon(0, {cs_a, ras_a, cas_a, we_a}, addr_a, ba_a, rdy_a, rdy_cyc_a, seen_a);
            mon(1, {cs_b, ras_b, cas_b, we_b}, addr_b, ba_b, rdy_b, rdy_cyc_b, seen_b);
        end
    end

    initial begin
        int wd;
        // A: ceil(125000*200/1000) = 25000; B: ceil(100003*200/1000) = 20001
        plan(0, 1'b0, 2, 25000, 3, 7, 2, mode_a, rdy_cyc_a);
        plan(1, 1'b1, 3, 20001, 2, 9, 3, mode_b, rdy_cyc_b);

        repeat (4) @(negedge clk);
        check({cs_a, ras_a, cas_a, we_a} == C_NOP, "R1", "A reset command",
              int'({cs_a, ras_a, cas_a, we_a}), int'(C_NOP));
        check({cs_b, ras_b, cas_b, we_b} == C_NOP, "R1", "B reset command",
              int'({cs_b, ras_b, cas_b, we_b}), int'(C_NOP));
        check(cke_a && (&dqm_a) && cke_b && (&dqm_b), "R1", "reset cke/dqm", 0, 1);
        check(!rdy_a && !rdy_b, "R1", "reset ready", int'(rdy_a | rdy_b), 0);

        running = 1;
        rst = 1'b0;

        wd = 0;
        while (!(seen_a && seen_b) && wd < 60000) begin
            @(negedge clk);
            wd++;
        end
        check(wd < 60000, "R8", "watchdog", wd, 60000);

        repeat (20) @(negedge clk);
        check(rdy_a && rdy_b, "R8", "ready held", int'(rdy_a & rdy_b), 1);
        check(q_a.size() == 0, "R4", "A commands left", q_a.size(), 0);
        check(q_b.size() == 0, "R6", "B commands left", q_b.size(), 0);
        check(!pins_bad, "R1", "cke/dqm high after reset", int'(pins_bad), 0);

        running = 0;
        rst = 1'b1;
        @(negedge clk);
        check(!rdy_a && !rdy_b, "R8", "ready cleared by reset", int'(rdy_a | rdy_b), 0);
        check({cs_a, ras_a, cas_a, we_a} == C_NOP, "R1", "NOP after re-reset",
              int'({cs_a, ras_a, cas_a, we_a}), int'(C_NOP));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule